// File: doc/BRIEF.md
# Compare-Select-Store Unit

This unit performs the select-and-log step of an add-compare-select decoder. The adder stage ahead of it packs two candidate path metrics into a single 40-bit accumulator word: one in the upper half of the low 32 bits and one in the lower half. When an operation is issued, the unit treats both 16-bit halves as signed two's-complement numbers. It picks the larger one and presents it on a store-data port with a one-cycle write strobe. The store address that came with the request is passed through alongside it.

Each decision is recorded in two places. A one-bit test/control flag shows which half won the most recent operation. A 16-bit decision-history register collects the outcomes in sequence, so a traceback routine can later walk back through the choices. Software empties the history before each new trellis with a synchronous clear input.

All work completes in one clock. A request captured on a rising edge has its result, flag and history update visible after that same edge.

Top module: `acs_select_store`

## Requirements
- R1: While the asynchronous active-low reset is held, the store strobe, store data, store address, flag and history are all zero.
- R2: An operation issued on a clock edge raises `st_we_o` for exactly the following cycle. In that cycle `st_data_o` holds the larger of the high word (bits 31:16) and the low word (bits 15:0), both compared as signed 16-bit values.
- R3: When the two words are equal, the high word is stored and the flag is 0.
- R4: After an operation, `tc_o` is 1 exactly when the low word was strictly greater than the high word. Otherwise it is 0.
- R5: Every operation shifts the history left by one. The new `tc_o` value enters at bit 0, and the oldest bit at bit 15 is discarded.
- R6: In a cycle with no operation and no clear, the flag, the history, the store data and the store address keep their values, and the strobe is low.
- R7: A clear forces history and flag to zero on the next edge. It takes priority over an operation in the same cycle, but that operation still produces its store.
- R8: Accumulator bits 39:32 have no effect on the stored word, the flag or the history.
- R9: `st_addr_o` shows the address presented with the operation in the same cycle as its strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid_i | input | 1 | Issue one compare-select operation this cycle |
| acc_i | input | 40 | Accumulator carrying both candidate words |
| addr_i | input | 16 | Destination address for the selected word |
| hist_clr_i | input | 1 | Synchronous clear of flag and history |
| st_data_o | output | 16 | Selected (larger) word |
| st_addr_o | output | 16 | Destination address of the selected word |
| st_we_o | output | 1 | Store strobe, one cycle per operation |
| tc_o | output | 1 | Latest decision: 1 when the low word won |
| trn_o | output | 16 | Decision history, newest decision at bit 0 |

## Verification
The hardest conditions to produce are the ones where the signed order and the unsigned order of the two words disagree, and the exact tie. A wrong comparison looks correct on every other input. The vector table therefore places 0x8000 against 0x7FFF in both halves, uses negative pairs, and includes an exact tie. It also sets the guard byte to a non-zero value. A run of seventeen consecutive low-wins decisions forces a history bit off the top of the register. A clear issued in the same cycle as an operation shows that the store still happens while the history comes out empty.

// File: rtl/acs_pkg.sv
package acs_pkg;
  localparam int unsigned ACC_W_DEF  = 40;
  localparam int unsigned WORD_W_DEF = 16;
  localparam int unsigned HIST_W_DEF = 16;
  localparam int unsigned ADDR_W_DEF = 16;

  typedef enum logic {
    PICK_HIGH = 1'b0,
    PICK_LOW  = 1'b1
  } pick_e;
endpackage

// File: rtl/acs_split.sv
module acs_split #(
  parameter int unsigned ACC_W  = acs_pkg::ACC_W_DEF,
  parameter int unsigned WORD_W = acs_pkg::WORD_W_DEF,
  localparam int unsigned GUARD_W = ACC_W - 2 * WORD_W
) (
  input  logic [ACC_W-1:0]   acc_i,
  output logic [WORD_W-1:0]  hi_o,
  output logic [WORD_W-1:0]  lo_o,
  output logic [GUARD_W-1:0] guard_o
);
  // Guard bits are exposed only so checks can see them; the select path ignores them.
  assign lo_o    = acc_i[WORD_W-1:0];
  assign hi_o    = acc_i[2*WORD_W-1:WORD_W];
  assign guard_o = acc_i[ACC_W-1:2*WORD_W];
endmodule

// File: rtl/acs_compare.sv
module acs_compare #(
  parameter int unsigned WORD_W = acs_pkg::WORD_W_DEF
) (
  input  logic [WORD_W-1:0] hi_i,
  input  logic [WORD_W-1:0] lo_i,
  output acs_pkg::pick_e    pick_o,
  output logic [WORD_W-1:0] win_o
);
  import acs_pkg::*;

  // Low side wins only on a strict signed excess; ties go to the high word.
  function automatic logic low_beats_high(input logic [WORD_W-1:0] h,
                                          input logic [WORD_W-1:0] l);
    return $signed(l) > $signed(h);
  endfunction

  function automatic logic [WORD_W-1:0] pick_word(input pick_e p,
                                                  input logic [WORD_W-1:0] h,
                                                  input logic [WORD_W-1:0] l);
    return (p == PICK_LOW) ? l : h;
  endfunction

  always_comb begin
    pick_o = low_beats_high(hi_i, lo_i) ? PICK_LOW : PICK_HIGH;
    win_o  = pick_word(pick_o, hi_i, lo_i);
  end
endmodule

// File: rtl/acs_history.sv
module acs_history #(
  parameter int unsigned HIST_W = acs_pkg::HIST_W_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_i,
  input  logic              bit_i,
  input  logic              clr_i,
  output logic              tc_o,
  output logic [HIST_W-1:0] trn_o
);
  logic [HIST_W-1:0] trn_shifted;

  generate
    if (HIST_W == 1) begin : g_single
      assign trn_shifted = bit_i;
    end else begin : g_shift
      assign trn_shifted = {trn_o[HIST_W-2:0], bit_i};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tc_o  <= 1'b0;
      trn_o <= '0;
    end else if (clr_i) begin
      tc_o  <= 1'b0;
      trn_o <= '0;
    end else if (step_i) begin
      tc_o  <= bit_i;
      trn_o <= trn_shifted;
    end
  end
endmodule

// File: rtl/acs_store.sv
module acs_store #(
  parameter int unsigned WORD_W = acs_pkg::WORD_W_DEF,
  parameter int unsigned ADDR_W = acs_pkg::ADDR_W_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [WORD_W-1:0] data_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              we_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_o <= '0;
      addr_o <= '0;
      we_o   <= 1'b0;
    end else begin
      we_o <= fire_i;
      if (fire_i) begin
        data_o <= word_i;
        addr_o <= addr_i;
      end
    end
  end
endmodule

// File: rtl/acs_select_store.sv
module acs_select_store #(
  parameter int unsigned ACC_W  = acs_pkg::ACC_W_DEF,
  parameter int unsigned WORD_W = acs_pkg::WORD_W_DEF,
  parameter int unsigned HIST_W = acs_pkg::HIST_W_DEF,
  parameter int unsigned ADDR_W = acs_pkg::ADDR_W_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid_i,
  input  logic [ACC_W-1:0]  acc_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              hist_clr_i,
  output logic [WORD_W-1:0] st_data_o,
  output logic [ADDR_W-1:0] st_addr_o,
  output logic              st_we_o,
  output logic              tc_o,
  output logic [HIST_W-1:0] trn_o
);
  import acs_pkg::*;
  localparam int unsigned GUARD_W = ACC_W - 2 * WORD_W;

  // Named internal events, visible to the bound checker.
  logic [WORD_W-1:0]  acc_hi;
  logic [WORD_W-1:0]  acc_lo;
  logic [GUARD_W-1:0] acc_guard;
  pick_e              pick;
  logic               pick_low;
  logic [WORD_W-1:0]  win_word;
  logic               op_fire;

  assign op_fire  = op_valid_i;
  assign pick_low = (pick == PICK_LOW);

  acs_split #(.ACC_W(ACC_W), .WORD_W(WORD_W)) u_split (
    .acc_i   (acc_i),
    .hi_o    (acc_hi),
    .lo_o    (acc_lo),
    .guard_o (acc_guard)
  );

  acs_compare #(.WORD_W(WORD_W)) u_cmp (
    .hi_i   (acc_hi),
    .lo_i   (acc_lo),
    .pick_o (pick),
    .win_o  (win_word)
  );

  acs_history #(.HIST_W(HIST_W)) u_hist (
    .clk    (clk),
    .rst_n  (rst_n),
    .step_i (op_fire),
    .bit_i  (pick_low),
    .clr_i  (hist_clr_i),
    .tc_o   (tc_o),
    .trn_o  (trn_o)
  );

  acs_store #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_store (
    .clk    (clk),
    .rst_n  (rst_n),
    .fire_i (op_fire),
    .word_i (win_word),
    .addr_i (addr_i),
    .data_o (st_data_o),
    .addr_o (st_addr_o),
    .we_o   (st_we_o)
  );
endmodule

// File: rtl/acs_select_store_chk.sv
module acs_select_store_chk #(
  parameter int unsigned WORD_W  = 16,
  parameter int unsigned HIST_W  = 16,
  parameter int unsigned ADDR_W  = 16,
  parameter int unsigned GUARD_W = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               op_valid_i,
  input logic               hist_clr_i,
  input logic [WORD_W-1:0]  acc_hi,
  input logic [WORD_W-1:0]  acc_lo,
  input logic [GUARD_W-1:0] acc_guard,
  input logic [ADDR_W-1:0]  addr_i,
  input logic               pick_low,
  input logic [WORD_W-1:0]  win_word,
  input logic [WORD_W-1:0]  st_data_o,
  input logic [ADDR_W-1:0]  st_addr_o,
  input logic               st_we_o,
  input logic               tc_o,
  input logic [HIST_W-1:0]  trn_o
);
  logic              lo_greater;
  logic [WORD_W-1:0] larger;
  assign lo_greater = $signed(acc_lo) > $signed(acc_hi);
  assign larger     = lo_greater ? acc_lo : acc_hi;

  assert_strobe_on_R2: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid_i |=> st_we_o);
  assert_strobe_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid_i |=> !st_we_o);
  assert_larger_word_R2: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid_i |=> st_data_o == $past(larger));
  assert_tie_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid_i && !hist_clr_i && acc_hi == acc_lo) |=> (!tc_o && st_data_o == $past(acc_hi)));
  assert_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid_i && !hist_clr_i) |=> tc_o == $past(lo_greater));
  assert_shift_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid_i && !hist_clr_i) |=> trn_o == {$past(trn_o[HIST_W-2:0]), tc_o});
  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!op_valid_i && !hist_clr_i) |=> ($stable(trn_o) && $stable(tc_o) && $stable(st_data_o)));
  assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    hist_clr_i |=> (trn_o == '0 && !tc_o));
  assert_guard_free_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid_i && acc_guard != '0) |=> st_data_o == $past(larger));
  assert_pick_word_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pick_low |-> win_word == acc_lo);
  assert_addr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid_i |=> st_addr_o == $past(addr_i));
endmodule

bind acs_select_store acs_select_store_chk #(
  .WORD_W(WORD_W), .HIST_W(HIST_W), .ADDR_W(ADDR_W), .GUARD_W(GUARD_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .op_valid_i (op_valid_i),
  .hist_clr_i (hist_clr_i),
  .acc_hi     (acc_hi),
  .acc_lo     (acc_lo),
  .acc_guard  (acc_guard),
  .addr_i     (addr_i),
  .pick_low   (pick_low),
  .win_word   (win_word),
  .st_data_o  (st_data_o),
  .st_addr_o  (st_addr_o),
  .st_we_o    (st_we_o),
  .tc_o       (tc_o),
  .trn_o      (trn_o)
);

// File: tb/acs_select_store_tb.sv
`timescale 1ns/1ps
module acs_select_store_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid_i = 1'b0;
  logic [39:0] acc_i = '0;
  logic [15:0] addr_i = '0;
  logic        hist_clr_i = 1'b0;
  logic [15:0] st_data_o;
  logic [15:0] st_addr_o;
  logic        st_we_o;
  logic        tc_o;
  logic [15:0] trn_o;

  int checks = 0;
  int errors = 0;
  logic [15:0] exp_trn = '0;
  logic        finished = 1'b0;

  always #10 clk = ~clk;

  acs_select_store u_dut (
    .clk(clk), .rst_n(rst_n), .op_valid_i(op_valid_i), .acc_i(acc_i),
    .addr_i(addr_i), .hist_clr_i(hist_clr_i), .st_data_o(st_data_o),
    .st_addr_o(st_addr_o), .st_we_o(st_we_o), .tc_o(tc_o), .trn_o(trn_o)
  );

  // Stimulus: guard byte, high word, low word; expected selected word and flag.
  localparam int NV = 8;
  localparam logic [39:0] V_ACC [NV] = '{
    40'h00_0005_0003, 40'h00_0003_0005, 40'h00_FFFF_0001, 40'h00_8000_7FFF,
    40'h00_7FFF_8000, 40'h00_1234_1234, 40'h00_FFFE_FFFD, 40'hAB_0001_0002
  };
  localparam logic [15:0] V_DATA [NV] = '{
    16'h0005, 16'h0005, 16'h0001, 16'h7FFF, 16'h7FFF, 16'h1234, 16'hFFFE, 16'h0002
  };
  localparam logic V_TC [NV] = '{1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1};

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Issue one operation, then sample after the edge that registers it.
  task automatic op(input logic [39:0] acc, input logic [15:0] addr, input logic clr);
    @(negedge clk);
    op_valid_i = 1'b1; acc_i = acc; addr_i = addr; hist_clr_i = clr;
    @(negedge clk);
    op_valid_i = 1'b0; hist_clr_i = 1'b0;
  endtask

  initial begin
    #(20.0 * 200000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    #35;
    check("R1 we", {15'd0, st_we_o}, 16'd0);
    check("R1 data", st_data_o, 16'd0);
    check("R1 trn", trn_o, 16'd0);
    check("R1 tc", {15'd0, tc_o}, 16'd0);
    @(negedge clk); rst_n = 1'b1;

    // R2/R3/R4/R5/R8/R9: table walk
    for (int i = 0; i < NV; i++) begin
      op(V_ACC[i], 16'h0100 + 16'(i), 1'b0);
      exp_trn = {exp_trn[14:0], V_TC[i]};
      check("R2 we", {15'd0, st_we_o}, 16'd1);
      check("R2/R3/R8 data", st_data_o, V_DATA[i]);
      check("R4/R3 tc", {15'd0, tc_o}, {15'd0, V_TC[i]});
      check("R5 trn", trn_o, exp_trn);
      check("R9 addr", st_addr_o, 16'h0100 + 16'(i));
    end
    check("R5 trn after table", trn_o, 16'h0071);

    // R6: idle cycle holds everything, strobe low
    @(negedge clk);
    check("R6 we", {15'd0, st_we_o}, 16'd0);
    check("R6 trn", trn_o, 16'h0071);
    check("R6 tc", {15'd0, tc_o}, 16'd1);
    check("R6 data", st_data_o, 16'h0002);
    check("R6 addr", st_addr_o, 16'h0107);

    // R8: guard byte only differs
    op(40'h00_8001_0004, 16'h0200, 1'b0);
    check("R8 data guard 00", st_data_o, 16'h0004);
    op(40'hFF_8001_0004, 16'h0201, 1'b0);
    check("R8 data guard FF", st_data_o, 16'h0004);
    check("R8 tc guard FF", {15'd0, tc_o}, 16'd1);

    // R7: clear alone
    @(negedge clk); hist_clr_i = 1'b1;
    @(negedge clk); hist_clr_i = 1'b0;
    check("R7 trn clear", trn_o, 16'd0);
    check("R7 tc clear", {15'd0, tc_o}, 16'd0);
    check("R7 no store", {15'd0, st_we_o}, 16'd0);

    // R5: seventeen low wins, then one high win drops the oldest bit
    for (int k = 0; k < 17; k++) op(40'h00_0000_0001, 16'h0300, 1'b0);
    check("R5 trn saturated", trn_o, 16'hFFFF);
    op(40'h00_0009_0001, 16'h0301, 1'b0);
    check("R5 trn oldest dropped", trn_o, 16'hFFFE);
    check("R4 tc high win", {15'd0, tc_o}, 16'd0);

    // R7: clear together with an operation
    op(40'h00_0000_0042, 16'h0400, 1'b1);
    check("R7 store still made", {15'd0, st_we_o}, 16'd1);
    check("R7 store data", st_data_o, 16'h0042);
    check("R7 trn priority", trn_o, 16'd0);
    check("R7 tc priority", {15'd0, tc_o}, 16'd0);

    // R1: asynchronous reset mid-run
    op(40'h00_0000_0007, 16'h0500, 1'b0);
    #3 rst_n = 1'b0;
    #2;
    check("R1 async trn", trn_o, 16'd0);
    check("R1 async data", st_data_o, 16'd0);
    check("R1 async we", {15'd0, st_we_o}, 16'd0);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule